// File: doc/BRIEF.md
# Absolute-Address Bus Cycle Sequencer

This block drives the memory bus, one cycle per clock, for instructions that name a full 16-bit operand address in the two bytes after the opcode. A decoder that has already fetched the opcode hands it a request. The request carries an access kind, a width flag, the program counter (already past the opcode) and the stack pointer. The sequencer then fetches the two operand bytes and builds the target address. It runs the data reads, writes or stack pushes that the access kind calls for, and raises a strobe in the cycle where the external ALU must act. It finishes with a one-cycle done pulse.

The ALU is outside the block. It sees the gathered data on `operand_out` and returns its result on `alu_result` in the same cycle. The sequencer captures that result, or puts it on the bus, in the cycle marked by `perform`. Jumps and subroutine calls leave the new program counter on `pc_out`. Calls also leave the lowered stack pointer on `sp_out`.

Top module: `abs_bus_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_rd`, `bus_wr`, `done`, `perform` and `busy` are all low.
- R2: A request is taken on a clock where `start` is high and `busy` is low. The two cycles after it are bus reads at PC and at PC+1. These return the low and then the high byte of the target address T, and PC moves past both.
- R3: A read (kind 0) reads T, and in 16-bit mode (`wide`=1) it also reads T+1. `perform` is high only in the done cycle. There `operand_out` holds the data, with the high byte zero in 8-bit mode.
- R4: A write (kind 1) stores `alu_result[7:0]` at T in the first data cycle, with `perform` high in that cycle. In 16-bit mode it then stores, at T+1, the high byte that `alu_result` held in that first cycle.
- R5: An 8-bit read-modify-write (kind 2, `wide`=0) reads T and writes the same byte back unchanged to T. It then writes `alu_result[7:0]` to T with `perform` high.
- R6: A 16-bit read-modify-write reads T, then T+1, then T+1 again. It writes `alu_result[15:8]` to T+1 with `perform` high, and then writes the low byte of that same result to T.
- R7: A jump (kind 3) makes no data access. Its done cycle comes right after the operand fetches, with `perform` high and `pc_out` equal to T.
- R8: A call (kind 4) does one discarded read at PC+2 after the operand fetches. It then writes the high byte of PC+1 at SP, with `perform` high, and the low byte at SP-1. At done, `pc_out` is T and `sp_out` is SP-2.
- R9: `done` is high for exactly one cycle, right after the last bus cycle, and `busy` is low in the next cycle. `start` has no effect while `busy` is high. `bus_rd` and `bus_wr` are never high together.
- R10: All address steps wrap modulo 2^ADDR_W. PC, data address and stack pointer each roll over from all-ones to zero and back.
- R11: For kinds other than jump and call, `pc_out` at done is PC+2 and `sp_out` equals the SP given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| kind | input | 3 | Access kind: 0 read, 1 write, 2 read-modify-write, 3 jump, 4 call |
| wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| pc_in | input | ADDR_W | Program counter after the opcode |
| sp_in | input | ADDR_W | Stack pointer |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| alu_result | input | 16 | ALU output, used in the perform cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| perform | output | 1 | ALU operate strobe |
| operand_out | output | 16 | Gathered data for the ALU |
| pc_out | output | ADDR_W | Program counter |
| sp_out | output | ADDR_W | Stack pointer |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ADDR_W=16. At that width, a directed PC of 0xFFFF, a target of 0xFFFF and a stack pointer of 0x0000 are reachable, so every increment and decrement path is driven across the rollover. Random requests vary the kind, width, PC, SP, target and ALU result. A second `start` is pulsed in the middle of each sequence, which shows that it is ignored while the block is busy.

// File: rtl/abs_bus_seq.sv
module abs_bus_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        kind,
  input  logic              wide,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [7:0]        bus_rdata,
  input  logic [15:0]       alu_result,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  output logic              perform,
  output logic [15:0]       operand_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              busy,
  output logic              done
);

  localparam logic [2:0] K_READ = 3'd0;
  localparam logic [2:0] K_WRITE = 3'd1;
  localparam logic [2:0] K_RMW = 3'd2;
  localparam logic [2:0] K_JUMP = 3'd3;
  localparam logic [2:0] K_CALL = 3'd4;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  typedef enum logic [4:0] {
    S_IDLE, S_OPL, S_OPH,
    S_RD_LO, S_RD_HI,
    S_WR_LO, S_WR_HI,
    S_M_RD, S_M_DUMMY, S_M_W8,
    S_M_RDH, S_M_REREAD, S_M_WH, S_M_WL,
    S_DISC, S_PUSH_H, S_PUSH_L,
    S_DONE
  } state_t;

  state_t            state;
  logic [2:0]        kind_q;
  logic              wide_q;
  logic [ADDR_W-1:0] pc_q, sp_q, addr_q;
  logic [15:0]       buf_q;
  logic [ADDR_W-1:0] ret_addr;

  assign ret_addr    = pc_q - ONE;
  assign operand_out = buf_q;
  assign pc_out      = pc_q;
  assign sp_out      = sp_q;
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      kind_q <= K_READ;
      wide_q <= 1'b0;
      pc_q   <= '0;
      sp_q   <= '0;
      addr_q <= '0;
      buf_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_OPL;
          kind_q <= kind;
          wide_q <= wide;
          pc_q   <= pc_in;
          sp_q   <= sp_in;
          buf_q  <= '0;
        end
        S_OPL: begin
          addr_q <= ADDR_W'(bus_rdata);
          pc_q   <= pc_q + ONE;
          state  <= S_OPH;
        end
        S_OPH: begin
          addr_q <= ADDR_W'({bus_rdata, addr_q[7:0]});
          case (kind_q)
            K_READ:  begin pc_q <= pc_q + ONE; state <= S_RD_LO; end
            K_WRITE: begin pc_q <= pc_q + ONE; state <= S_WR_LO; end
            K_RMW:   begin pc_q <= pc_q + ONE; state <= S_M_RD; end
            K_JUMP:  begin pc_q <= ADDR_W'({bus_rdata, addr_q[7:0]}); state <= S_DONE; end
            K_CALL:  begin pc_q <= pc_q + ONE; state <= S_DISC; end
            default: begin pc_q <= pc_q + ONE; state <= S_DONE; end
          endcase
        end
        S_RD_LO: begin
          buf_q[7:0] <= bus_rdata;
          addr_q     <= addr_q + ONE;
          state      <= wide_q ? S_RD_HI : S_DONE;
        end
        S_RD_HI: begin
          buf_q[15:8] <= bus_rdata;
          state       <= S_DONE;
        end
        S_WR_LO: begin
          buf_q  <= alu_result;
          addr_q <= addr_q + ONE;
          state  <= wide_q ? S_WR_HI : S_DONE;
        end
        S_WR_HI: state <= S_DONE;
        S_M_RD: begin
          buf_q[7:0] <= bus_rdata;
          if (wide_q) begin
            addr_q <= addr_q + ONE;
            state  <= S_M_RDH;
          end else begin
            state  <= S_M_DUMMY;
          end
        end
        S_M_DUMMY: state <= S_M_W8;
        S_M_W8: begin
          buf_q <= alu_result;
          state <= S_DONE;
        end
        S_M_RDH: begin
          buf_q[15:8] <= bus_rdata;
          state       <= S_M_REREAD;
        end
        S_M_REREAD: begin
          buf_q[15:8] <= bus_rdata;
          state       <= S_M_WH;
        end
        S_M_WH: begin
          buf_q  <= alu_result;
          addr_q <= addr_q - ONE;
          state  <= S_M_WL;
        end
        S_M_WL: state <= S_DONE;
        S_DISC: state <= S_PUSH_H;
        S_PUSH_H: begin
          sp_q  <= sp_q - ONE;
          state <= S_PUSH_L;
        end
        S_PUSH_L: begin
          sp_q  <= sp_q - ONE;
          pc_q  <= addr_q;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr  = addr_q;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
    perform   = 1'b0;
    done      = 1'b0;
    case (state)
      S_OPL, S_OPH, S_DISC: begin
        bus_addr = pc_q;
        bus_rd   = 1'b1;
      end
      S_RD_LO, S_RD_HI, S_M_RD, S_M_RDH, S_M_REREAD: bus_rd = 1'b1;
      S_WR_LO: begin
        bus_wr    = 1'b1;
        bus_wdata = alu_result[7:0];
        perform   = 1'b1;
      end
      S_WR_HI: begin
        bus_wr    = 1'b1;
        bus_wdata = buf_q[15:8];
      end
      S_M_DUMMY, S_M_WL: begin
        bus_wr    = 1'b1;
        bus_wdata = buf_q[7:0];
      end
      S_M_W8: begin
        bus_wr    = 1'b1;
        bus_wdata = alu_result[7:0];
        perform   = 1'b1;
      end
      S_M_WH: begin
        bus_wr    = 1'b1;
        bus_wdata = alu_result[15:8];
        perform   = 1'b1;
      end
      S_PUSH_H: begin
        bus_addr  = sp_q;
        bus_wr    = 1'b1;
        bus_wdata = ret_addr[15:8];
        perform   = 1'b1;
      end
      S_PUSH_L: begin
        bus_addr  = sp_q;
        bus_wr    = 1'b1;
        bus_wdata = ret_addr[7:0];
      end
      S_DONE: begin
        done    = 1'b1;
        perform = (kind_q == K_READ) || (kind_q == K_JUMP);
      end
      default: ;
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_rd && !bus_wr && !done && !perform && !busy));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R2
  operand_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_OPH) |-> (bus_rd && bus_addr == $past(bus_addr) + ONE));

  // R5
  dummy_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_M_W8) |-> ($past(bus_wr) && bus_addr == $past(bus_addr)));

  // R6
  rmw_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_M_WL) |-> ($past(perform) && bus_addr == $past(bus_addr) - ONE));

  // R8
  push_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_PUSH_L) |-> ($past(perform) && bus_addr == $past(bus_addr) - ONE));

endmodule

// File: tb/abs_bus_seq_tb.sv
module abs_bus_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        wide = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] alu_result;
  logic [15:0] bus_addr, pc_out, sp_out, operand_out;
  logic        bus_rd, bus_wr, perform, busy, done;
  logic [7:0]  bus_wdata;

  logic [15:0] opa = '0, tgt = '0, key = '0;
  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  logic        e_rd [8], e_wr [8], e_pf [8];
  logic [15:0] e_ad [8];
  logic [7:0]  e_wd [8];
  int          e_n;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd3;
    return m ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] mread(input logic [15:0] a);
    if (a == opa) return tgt[7:0];
    if (a == opa + 16'd1) return tgt[15:8];
    return memf(a);
  endfunction

  assign bus_rdata  = mread(bus_addr);
  assign alu_result = operand_out ^ key;

  abs_bus_seq #(.ADDR_W(16)) u_dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .wide(wide),
    .pc_in(pc_in), .sp_in(sp_in), .bus_rdata(bus_rdata), .alu_result(alu_result),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .perform(perform), .operand_out(operand_out), .pc_out(pc_out), .sp_out(sp_out),
    .busy(busy), .done(done)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic rd, input logic wr, input logic [15:0] ad, input logic [7:0] wd, input logic pf);
    e_rd[e_n] = rd; e_wr[e_n] = wr; e_ad[e_n] = ad; e_wd[e_n] = wd; e_pf[e_n] = pf;
    e_n++;
  endtask

  task automatic run(input logic [2:0] k, input logic w, input logic [15:0] pc,
                     input logic [15:0] sp, input logic [15:0] tg, input logic [15:0] ky);
    logic [15:0] d, r, ret, epc, esp;
    string req;
    opa = pc; tgt = tg; key = ky;
    e_n = 0;
    d = w ? {mread(tg + 16'd1), mread(tg)} : {8'h00, mread(tg)};
    r = d ^ ky;
    ret = pc + 16'd1;
    epc = pc + 16'd2;
    esp = sp;
    push(1, 0, pc, 0, 0);
    push(1, 0, pc + 16'd1, 0, 0);
    case (k)
      3'd0: begin
        req = "R3";
        push(1, 0, tg, 0, 0);
        if (w) push(1, 0, tg + 16'd1, 0, 0);
      end
      3'd1: begin
        req = "R4";
        push(0, 1, tg, ky[7:0], 1);
        if (w) push(0, 1, tg + 16'd1, ky[15:8], 0);
      end
      3'd2: begin
        if (w) begin
          req = "R6";
          push(1, 0, tg, 0, 0);
          push(1, 0, tg + 16'd1, 0, 0);
          push(1, 0, tg + 16'd1, 0, 0);
          push(0, 1, tg + 16'd1, r[15:8], 1);
          push(0, 1, tg, r[7:0], 0);
        end else begin
          req = "R5";
          push(1, 0, tg, 0, 0);
          push(0, 1, tg, d[7:0], 0);
          push(0, 1, tg, r[7:0], 1);
        end
      end
      3'd3: begin
        req = "R7";
        epc = tg;
      end
      default: begin
        req = "R8";
        push(1, 0, pc + 16'd2, 0, 0);
        push(0, 1, sp, ret[15:8], 1);
        push(0, 1, sp - 16'd1, ret[7:0], 0);
        epc = tg;
        esp = sp - 16'd2;
      end
    endcase
    @(negedge clk);
    start = 1; kind = k; wide = w; pc_in = pc; sp_in = sp;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < e_n; i++) begin
      if (i == 1) begin start = 1; kind = 3'd3; wide = ~w; pc_in = ~pc; sp_in = ~sp; end
      chk({bus_rd, bus_wr, bus_addr, (bus_wr ? bus_wdata : 8'h00), perform, done} ==
          {e_rd[i], e_wr[i], e_ad[i], (e_wr[i] ? e_wd[i] : 8'h00), e_pf[i], 1'b0},
          (i < 2) ? "R2" : req,
          {bus_rd, bus_wr, bus_addr, bus_wdata, perform, done},
          {e_rd[i], e_wr[i], e_ad[i], e_wd[i], e_pf[i], 1'b0});
      @(negedge clk);
      start = 0;
    end
    // R9 done right after last bus cycle; R7 and R3 perform in done cycle
    chk(done && busy && !bus_rd && !bus_wr, "R9", {done, busy, bus_rd, bus_wr}, 4'b1100);
    chk(perform == (k == 3'd0 || k == 3'd3), req, perform, (k == 3'd0 || k == 3'd3));
    chk(pc_out == epc && sp_out == esp, (k >= 3'd3) ? req : "R11", {pc_out, sp_out}, {epc, esp});
    if (k == 3'd0) chk(operand_out == d, "R3", operand_out, d);
    @(negedge clk);
    chk(!done && !busy, "R9", {done, busy}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(!bus_rd && !bus_wr && !done && !perform && !busy, "R1",
        {bus_rd, bus_wr, done, perform, busy}, 5'b0);
    @(negedge clk);
    rst = 0;
    // R1 idle after reset release
    chk(!bus_rd && !bus_wr && !busy, "R1", {bus_rd, bus_wr, busy}, 3'b0);
    for (int k = 0; k < 5; k++) begin
      run(3'(k), 1'b0, 16'h1000, 16'h01FF, 16'h2345, 16'hA55A);
      run(3'(k), 1'b1, 16'h1000, 16'h01FF, 16'h2345, 16'hA55A);
    end
    // R10 wrap corners
    for (int k = 0; k < 5; k++) begin
      run(3'(k), 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0F0F);
      run(3'(k), 1'b0, 16'hFFFE, 16'h0001, 16'hFFFF, 16'hF00F);
    end
    for (int n = 0; n < 400; n++) begin
      run(3'($urandom % 5), 1'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom));
    end
    // R9 start ignored while busy and sequence returns to idle
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R9", {busy, bus_rd, bus_wr}, 3'b0);
    summary();
  end
endmodule